// File: doc/BRIEF.md
# Bus Data-Beat Acknowledge Controller

This controller sits on the target side of a processor bus where the address and data phases are separate. Once a transfer start has been seen, it follows the data phase. It issues a one-cycle acknowledge for each data beat the memory side can complete. It inserts wait states whenever the memory side is not ready, when the address phase has not yet been acknowledged, or when a minimum delay for burst reads has not yet passed. That minimum depends on the clock ratio.

A transfer is either a single beat or a burst of four beats. The tenure ends on the final acknowledge. It can also be cut short by an error acknowledge, but only while the error-enable input is set. A beat counter shows how many beats have completed so far in the current or most recent tenure.

Top module: `beat_ack_ctrl`

## Requirements
- R1: `ack` is never high in a transaction before `addr_ack` has been high at some point since that transaction's `xfer_start`. A cycle in which `addr_ack` itself is high counts as seen.
- R2: `ack` is high only in cycles where `dbusy` is high.
- R3: `ack` is high only in cycles where `mem_ready` is high. Every eligible cycle with `mem_ready` low is one wait state, and the beat completes on the next cycle with `mem_ready` high.
- R4: A single transfer (`burst`=0) ends after one `ack`. A burst (`burst`=1) ends after four `ack` pulses, and these may be separated by wait states.
- R5: For a burst read (`burst`=1, `is_read`=1), the first `ack` comes no earlier than the third cycle after the `xfer_start` cycle (two wait states) when `ratio_sel`=0, and no earlier than the second cycle (one wait state) when `ratio_sel`=1. All other transfers may acknowledge as early as the first cycle after start.
- R6: When `err_en`=0, `err_req` has no effect: `err_ack` stays low and the beats continue as normal.
- R7: When `err_en`=1, `err_ack` is high in a cycle where a tenure is active, `dbusy` is high and `err_req` is high. The tenure is then aborted, so neither `ack` nor `err_ack` is high in the next cycle.
- R8: `ack` and `err_ack` are never high in the same cycle. When both would occur, `err_ack` wins.
- R9: `beat_cnt` becomes 0 in the cycle after an accepted `xfer_start`. It rises by one (mod 4) in the cycle after each `ack`.
- R10: Outside a tenure, `ack` and `err_ack` stay low whatever the values of `mem_ready`, `dbusy`, `addr_ack` and `err_req`. The same holds after reset, when `beat_cnt` is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Transfer start pulse |
| burst | input | 1 | 1 = four-beat burst, 0 = single beat (sampled with start) |
| is_read | input | 1 | 1 = read, 0 = write (sampled with start) |
| addr_ack | input | 1 | Address acknowledge |
| dbusy | input | 1 | Data bus busy |
| mem_ready | input | 1 | Memory side can complete the current beat |
| err_req | input | 1 | Request to end the tenure with an error |
| err_en | input | 1 | Error acknowledge enable |
| ratio_sel | input | 1 | 0 = 1:1 clock ratio, 1 = 1.5:1 ratio |
| ack | output | 1 | Transfer acknowledge, one cycle per beat |
| err_ack | output | 1 | Transfer error acknowledge |
| beat_cnt | output | 2 | Beats completed in the current/last tenure, mod 4 |

## Verification
The two functions that can fall in the same cycle are beat completion and error termination. The bench provokes the clash in the middle of a burst, with `mem_ready` and `err_req` both high and the error enabled. It expects `err_ack` high and `ack` low in that cycle. In the next cycle it expects both low even though `mem_ready` stays high, and it expects the beat count to be frozen at the number of beats completed before the error. The same stimulus is then repeated with the error disabled. There the expected outcome is an uninterrupted four-beat burst.

// File: rtl/beat_ack_ctrl.sv
module beat_ack_ctrl #(
  parameter int BURST_BEATS = 4,
  parameter int MIN_WS_FULL = 2,
  parameter int MIN_WS_HALF = 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           xfer_start,
  input  logic                           burst,
  input  logic                           is_read,
  input  logic                           addr_ack,
  input  logic                           dbusy,
  input  logic                           mem_ready,
  input  logic                           err_req,
  input  logic                           err_en,
  input  logic                           ratio_sel,
  output logic                           ack,
  output logic                           err_ack,
  output logic [$clog2(BURST_BEATS)-1:0] beat_cnt
);
  localparam int BW   = $clog2(BURST_BEATS);
  localparam int KMAX = (MIN_WS_FULL > MIN_WS_HALF) ? MIN_WS_FULL + 1 : MIN_WS_HALF + 1;
  localparam int CW   = $clog2(KMAX + 1);

  logic          busy_q, burst_q, aack_q;
  logic [CW-1:0] cyc_q, need_q;
  logic [BW-1:0] beat_q;
  logic [CW-1:0] need_d;
  logic          gate, err_fire, last;

  assign need_d   = (burst && is_read) ? (ratio_sel ? CW'(MIN_WS_HALF + 1) : CW'(MIN_WS_FULL + 1))
                                       : CW'(1);
  assign gate     = busy_q && dbusy && (aack_q || addr_ack) && (cyc_q >= need_q);
  assign err_fire = busy_q && dbusy && err_en && err_req;
  assign last     = !burst_q || (beat_q == BW'(BURST_BEATS - 1));

  assign ack      = gate && mem_ready && !err_fire;
  assign err_ack  = err_fire;
  assign beat_cnt = beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      burst_q <= 1'b0;
      aack_q  <= 1'b0;
      cyc_q   <= '0;
      need_q  <= '0;
      beat_q  <= '0;
    end else if (!busy_q) begin
      if (xfer_start) begin
        busy_q  <= 1'b1;
        burst_q <= burst;
        need_q  <= need_d;
        cyc_q   <= CW'(1);
        aack_q  <= addr_ack;
        beat_q  <= '0;
      end
    end else begin
      if (addr_ack) aack_q <= 1'b1;
      if (cyc_q < CW'(KMAX)) cyc_q <= cyc_q + CW'(1);
      if (err_fire) begin
        busy_q <= 1'b0;
      end else if (ack) begin
        beat_q <= beat_q + BW'(1);
        if (last) busy_q <= 1'b0;
      end
    end
  end
endmodule

module beat_ack_ctrl_chk #(
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dbusy,
  input logic          mem_ready,
  input logic          err_en,
  input logic          ack,
  input logic          err_ack,
  input logic [BW-1:0] beat_cnt
);
  // R8
  ack_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(ack && err_ack));
  // R2
  ack_dbusy_chk: assert property (@(posedge clk) disable iff (!rst_n) ack |-> dbusy);
  // R3
  ack_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) ack |-> mem_ready);
  // R6
  err_masked_chk: assert property (@(posedge clk) disable iff (!rst_n) !err_en |-> !err_ack);
  // R7
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n) err_ack |=> (!ack && !err_ack));
  // R9
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (beat_cnt == $past(beat_cnt) + BW'(1)));
  // R7
  beat_hold_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_ack |=> $stable(beat_cnt));
endmodule

bind beat_ack_ctrl beat_ack_ctrl_chk #(.BW($clog2(BURST_BEATS))) u_chk (
  .clk(clk), .rst_n(rst_n), .dbusy(dbusy), .mem_ready(mem_ready), .err_en(err_en),
  .ack(ack), .err_ack(err_ack), .beat_cnt(beat_cnt)
);

// File: tb/tb_beat_ack_ctrl.sv
`timescale 1ns/1ps
module tb_beat_ack_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_start = 0, burst = 0, is_read = 0, addr_ack = 0, dbusy = 0;
  logic mem_ready = 0, err_req = 0, err_en = 0, ratio_sel = 0;
  logic ack, err_ack;
  logic [1:0] beat_cnt;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  beat_ack_ctrl dut (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .burst(burst), .is_read(is_read),
    .addr_ack(addr_ack), .dbusy(dbusy), .mem_ready(mem_ready), .err_req(err_req),
    .err_en(err_en), .ratio_sel(ratio_sel), .ack(ack), .err_ack(err_ack), .beat_cnt(beat_cnt)
  );

  task automatic check1(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_beat(input string req, input logic [1:0] exp);
    n_chk++;
    if (beat_cnt !== exp) begin
      n_bad++;
      $display("FAIL %s beat_cnt: actual %0d expected %0d at %0t", req, beat_cnt, exp, $time);
    end
  endtask

  // drive one cycle's inputs at the falling edge, then compare the outputs before the rising edge
  task automatic cyc(input logic ts, input logic aa, input logic db, input logic rdy, input logic er,
                     input logic e_ack, input logic e_err, input string req);
    @(negedge clk);
    xfer_start = ts; addr_ack = aa; dbusy = db; mem_ready = rdy; err_req = er;
    #2;
    check1(req, "ack", ack, e_ack);
    check1(req, "err_ack", err_ack, e_err);
  endtask

  task automatic idle_cycle();
    cyc(0, 0, 0, 0, 0, 0, 0, "R10");
  endtask

  task automatic t_reset();
    @(negedge clk); #2;
    check1("R10", "ack after reset", ack, 1'b0);
    check1("R10", "err_ack after reset", err_ack, 1'b0);
    check_beat("R10", 2'd0);
    cyc(0, 1, 1, 1, 1, 0, 0, "R10");
  endtask

  task automatic t_single_write();
    burst = 0; is_read = 0; err_en = 0;
    cyc(1, 1, 1, 1, 0, 0, 0, "R4");
    cyc(0, 0, 1, 1, 0, 1, 0, "R4");
    check_beat("R9", 2'd0);
    cyc(0, 0, 1, 1, 0, 0, 0, "R4");
    check_beat("R9", 2'd1);
    cyc(0, 0, 1, 1, 0, 0, 0, "R10");
  endtask

  task automatic t_burst(input logic rd, input logic rs, input int first, input string req);
    burst = 1; is_read = rd; ratio_sel = rs; err_en = 0;
    cyc(1, 1, 1, 1, 0, 0, 0, req);
    for (int k = 1; k < first; k++) cyc(0, 0, 1, 1, 0, 0, 0, req);
    for (int b = 0; b < 4; b++) begin
      cyc(0, 0, 1, 1, 0, 1, 0, "R4");
      check_beat("R9", 2'(b));
    end
    cyc(0, 0, 1, 1, 0, 0, 0, "R4");
    check_beat("R9", 2'd0);
    idle_cycle();
  endtask

  task automatic t_late_aack();
    burst = 0; is_read = 1; err_en = 0;
    cyc(1, 0, 1, 1, 0, 0, 0, "R1");
    cyc(0, 0, 1, 1, 0, 0, 0, "R1");
    cyc(0, 0, 1, 1, 0, 0, 0, "R1");
    cyc(0, 1, 1, 1, 0, 1, 0, "R1");
    cyc(0, 0, 1, 1, 0, 0, 0, "R4");
  endtask

  task automatic t_wait_states();
    burst = 1; is_read = 0; err_en = 0;
    cyc(1, 1, 1, 0, 0, 0, 0, "R3");
    cyc(0, 0, 1, 1, 0, 1, 0, "R3");
    cyc(0, 0, 1, 0, 0, 0, 0, "R3");
    cyc(0, 0, 1, 0, 0, 0, 0, "R3");
    cyc(0, 0, 1, 1, 0, 1, 0, "R3");
    check_beat("R9", 2'd1);
    cyc(0, 0, 1, 0, 0, 0, 0, "R3");
    check_beat("R9", 2'd2);
    cyc(0, 0, 1, 1, 0, 1, 0, "R3");
    cyc(0, 0, 1, 1, 0, 1, 0, "R4");
    cyc(0, 0, 1, 1, 0, 0, 0, "R4");
  endtask

  task automatic t_dbusy_gate();
    burst = 0; is_read = 0; err_en = 0;
    cyc(1, 1, 0, 1, 0, 0, 0, "R2");
    cyc(0, 0, 0, 1, 0, 0, 0, "R2");
    cyc(0, 0, 0, 1, 0, 0, 0, "R2");
    cyc(0, 0, 1, 1, 0, 1, 0, "R2");
    cyc(0, 0, 1, 1, 0, 0, 0, "R10");
  endtask

  task automatic t_error(input logic en);
    burst = 1; is_read = 0; err_en = en;
    cyc(1, 1, 1, 1, 0, 0, 0, "R7");
    cyc(0, 0, 1, 1, 0, 1, 0, "R7");
    cyc(0, 0, 1, 1, 0, 1, 0, "R7");
    if (en) begin
      cyc(0, 0, 1, 1, 1, 0, 1, "R8");
      cyc(0, 0, 1, 1, 0, 0, 0, "R7");
      check_beat("R7", 2'd2);
      cyc(0, 0, 1, 1, 1, 0, 0, "R10");
    end else begin
      cyc(0, 0, 1, 1, 1, 1, 0, "R6");
      cyc(0, 0, 1, 1, 1, 1, 0, "R6");
      cyc(0, 0, 1, 1, 1, 0, 0, "R6");
      check_beat("R6", 2'd0);
    end
    idle_cycle();
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single_write();
    t_burst(1, 0, 3, "R5");
    t_burst(1, 1, 2, "R5");
    t_burst(0, 0, 1, "R5");
    t_late_aack();
    t_wait_states();
    t_dbusy_gate();
    t_error(1);
    t_error(0);
    idle_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule